// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a fully associative cache of address translations. Each slot holds a virtual page number, the address-space identifier of the process that owns the mapping, a physical frame number, a small permission field, and two flags: valid and wired. A lookup presents a page number together with the current address-space identifier. In the same cycle, the block answers with a hit and the frame and permissions, or with a miss.

Because every slot carries its own address-space tag, translations from several processes can sit in the cache together. A context switch therefore needs no flush. After a miss, the external page walker supplies the translation on the fill port, and it is written on the next clock edge.

The entry chosen for a new translation follows a fixed order. A slot that already maps the same page and identifier is reused first. If there is none, the lowest-index free non-wired slot is used. If there is none of those either, a round-robin pointer picks among the non-wired slots. Wired slots are pinned: replacement and flushes never touch them. Software can flush all non-wired slots, or only the non-wired slots that carry one identifier.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose page number and address-space identifier both equal the presented ones. The hit, frame and permission outputs follow the lookup inputs combinationally, in the same cycle.
- R2: On a miss, `lkp_hit_o` is 0 and `lkp_pfn_o` and `lkp_perm_o` are all zeros.
- R3: A fill presented with `fill_en_i` high is written on the next rising edge. From then on, a lookup of that page and identifier hits with the supplied frame and permissions.
- R4: A fill whose page number and identifier already match a valid slot overwrites that slot in place, so no second copy is created. The slot's wired flag becomes the OR of its old value and `fill_wired_i`.
- R5: When there is no such match, the fill goes to the lowest-index slot that is neither valid nor wired.
- R6: When every non-wired slot is valid, the victim is the first non-wired slot at or after a round-robin pointer, searching upward with wrap-around. The pointer is 0 after reset and moves to the victim index plus one (modulo the entry count) after each such eviction.
- R7: A wired slot is never chosen as a victim and stays valid until reset.
- R8: If every slot is wired and the fill matches no slot, the fill is dropped and `fill_err_o` is high for exactly the following cycle.
- R9: `flush_all_i` clears the valid flag of every non-wired slot on the next edge. Wired slots keep hitting.
- R10: `flush_asid_en_i` clears only the non-wired slots whose identifier equals `flush_asid_i`. All other slots keep hitting.
- R11: When a fill and a flush arrive in the same cycle, the slot being written ends valid with the new translation, and the flush acts on every other slot.
- R12: While reset is low and just after it is released, every slot is invalid and unwired, lookups miss, and `fill_err_o` is 0.
- R13: A lookup in the same cycle as a fill of the same page sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_vpn_i | input | VPN_W | Page number to translate |
| lkp_asid_i | input | ASID_W | Current address-space identifier |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_pfn_o | output | PFN_W | Frame number on hit, zero on miss |
| lkp_perm_o | output | PERM_W | Permission bits on hit, zero on miss |
| fill_en_i | input | 1 | Write a translation this cycle |
| fill_vpn_i | input | VPN_W | Page number to write |
| fill_asid_i | input | ASID_W | Identifier to write |
| fill_pfn_i | input | PFN_W | Frame number to write |
| fill_perm_i | input | PERM_W | Permission bits to write |
| fill_wired_i | input | 1 | Pin the written slot |
| fill_err_o | output | 1 | Previous cycle's fill was dropped |
| flush_all_i | input | 1 | Invalidate all non-wired slots |
| flush_asid_en_i | input | 1 | Invalidate non-wired slots of one identifier |
| flush_asid_i | input | ASID_W | Identifier for the selective flush |

## Verification
Two pairs of events can fall in the same cycle. The first is a fill arriving together with a full or per-identifier flush. The second is a lookup arriving together with a fill of the same page. The bench drives each pair in a single cycle. It then checks on later lookups that the written slot survived (R11), and that the lookup in the fill cycle saw only the earlier state (R13). A reference model of the slot array, built from the requirements, predicts every cycle's outputs, including which slot a later eviction will displace.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FILL_UPDATE = 2'd0,
    FILL_FREE   = 2'd1,
    FILL_EVICT  = 2'd2,
    FILL_DROP   = 2'd3
  } fill_kind_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [VPN_W-1:0]                 wr_vpn_i,
  input  logic [ASID_W-1:0]                wr_asid_i,
  input  logic [PFN_W-1:0]                 wr_pfn_i,
  input  logic [PERM_W-1:0]                wr_perm_i,
  input  logic                             wr_wired_i,
  input  logic                             flush_all_i,
  input  logic                             flush_asid_en_i,
  input  logic [ASID_W-1:0]                flush_asid_i,
  output logic [ENTRIES-1:0]               valid_o,
  output logic [ENTRIES-1:0]               wired_o,
  output logic [ENTRIES-1:0][VPN_W-1:0]    vpn_o,
  output logic [ENTRIES-1:0][ASID_W-1:0]   asid_o,
  output logic [ENTRIES-1:0][PFN_W-1:0]    pfn_o,
  output logic [ENTRIES-1:0][PERM_W-1:0]   perm_o
);
  logic [ENTRIES-1:0]             valid_q, wired_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      wired_q <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
      perm_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        // write beats flush for the slot being filled
        if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          wired_q[i] <= wired_q[i] | wr_wired_i;
          vpn_q[i]   <= wr_vpn_i;
          asid_q[i]  <= wr_asid_i;
          pfn_q[i]   <= wr_pfn_i;
          perm_q[i]  <= wr_perm_i;
        end else if (!wired_q[i] &&
                     (flush_all_i || (flush_asid_en_i && asid_q[i] == flush_asid_i))) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign wired_o = wired_q;
  assign vpn_o   = vpn_q;
  assign asid_o  = asid_q;
  assign pfn_o   = pfn_q;
  assign perm_o  = perm_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    AST_WIRED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wired_q[g] |=> (wired_q[g] && valid_q[g])); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_all_i && !wired_q[g] && !(wr_en_i && wr_idx_i == IDX_W'(g))) |=> !valid_q[g]); // R9
    AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == IDX_W'(g)) |=>
        (valid_q[g] && vpn_q[g] == $past(wr_vpn_i) && pfn_q[g] == $past(wr_pfn_i))); // R3
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ENTRIES-1:0]               valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]    vpn_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0]   asid_i,
  input  logic [ENTRIES-1:0][PFN_W-1:0]    pfn_i,
  input  logic [ENTRIES-1:0][PERM_W-1:0]   perm_i,
  input  logic [VPN_W-1:0]                 lkp_vpn_i,
  input  logic [ASID_W-1:0]                lkp_asid_i,
  input  logic [VPN_W-1:0]                 upd_vpn_i,
  input  logic [ASID_W-1:0]                upd_asid_i,
  output logic                             lkp_hit_o,
  output logic [PFN_W-1:0]                 lkp_pfn_o,
  output logic [PERM_W-1:0]                lkp_perm_o,
  output logic                             upd_hit_o,
  output logic [IDX_W-1:0]                 upd_idx_o
);
  logic [ENTRIES-1:0] lkp_vec, upd_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lkp_vec[g] = valid_i[g] && vpn_i[g] == lkp_vpn_i && asid_i[g] == lkp_asid_i;
    assign upd_vec[g] = valid_i[g] && vpn_i[g] == upd_vpn_i && asid_i[g] == upd_asid_i;
  end

  always_comb begin
    lkp_pfn_o  = '0;
    lkp_perm_o = '0;
    upd_idx_o  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lkp_pfn_o  |= {PFN_W{lkp_vec[i]}} & pfn_i[i];
      lkp_perm_o |= {PERM_W{lkp_vec[i]}} & perm_i[i];
      if (upd_vec[i]) upd_idx_o |= IDX_W'(i);
    end
  end

  assign lkp_hit_o = |lkp_vec;
  assign upd_hit_o = |upd_vec;

  // no duplicate translation may ever be stored
  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_vec)); // R4
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> (lkp_pfn_o == '0 && lkp_perm_o == '0)); // R2
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] wired_i,
  input  logic               upd_hit_i,
  input  logic [IDX_W-1:0]   upd_idx_i,
  output fill_kind_e         kind_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0]   rr_q;
  logic [ENTRIES-1:0] free_vec;
  logic               free_found, rr_found;
  logic [IDX_W-1:0]   free_idx, rr_idx;
  logic [IDX_W:0]     pos;

  assign free_vec = ~valid_i & ~wired_i;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  // circular scan upward from the pointer
  always_comb begin
    rr_found = 1'b0;
    rr_idx   = '0;
    pos      = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      pos = {1'b0, rr_q} + (IDX_W + 1)'(k);
      if (pos >= (IDX_W + 1)'(ENTRIES)) pos = pos - (IDX_W + 1)'(ENTRIES);
      if (!rr_found && !wired_i[pos[IDX_W-1:0]]) begin
        rr_found = 1'b1;
        rr_idx   = pos[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    if (upd_hit_i) begin
      kind_o = FILL_UPDATE;
      idx_o  = upd_idx_i;
    end else if (free_found) begin
      kind_o = FILL_FREE;
      idx_o  = free_idx;
    end else if (rr_found) begin
      kind_o = FILL_EVICT;
      idx_o  = rr_idx;
    end else begin
      kind_o = FILL_DROP;
      idx_o  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fire_i && kind_o == FILL_EVICT) begin
      rr_q <= (idx_o == IDX_W'(ENTRIES - 1)) ? '0 : idx_o + 1'b1;
    end
  end

  AST_VICTIM_UNPINNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && (kind_o == FILL_FREE || kind_o == FILL_EVICT)) |-> !wired_i[idx_o]); // R7
  AST_EVICT_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && kind_o == FILL_EVICT) |-> valid_i[idx_o]); // R5
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  output logic              lkp_hit_o,
  output logic [PFN_W-1:0]  lkp_pfn_o,
  output logic [PERM_W-1:0] lkp_perm_o,
  input  logic              fill_en_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic              fill_wired_i,
  output logic              fill_err_o,
  input  logic              flush_all_i,
  input  logic              flush_asid_en_i,
  input  logic [ASID_W-1:0] flush_asid_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid, wired;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] asid;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
  logic [ENTRIES-1:0][PERM_W-1:0] perm;
  logic                           upd_hit, wr_en, err_q;
  logic [IDX_W-1:0]               upd_idx, vic_idx;
  fill_kind_e                     kind;

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .PERM_W(PERM_W)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(vic_idx),
    .wr_vpn_i(fill_vpn_i), .wr_asid_i(fill_asid_i),
    .wr_pfn_i(fill_pfn_i), .wr_perm_i(fill_perm_i), .wr_wired_i(fill_wired_i),
    .flush_all_i, .flush_asid_en_i, .flush_asid_i,
    .valid_o(valid), .wired_o(wired), .vpn_o(vpn), .asid_o(asid),
    .pfn_o(pfn), .perm_o(perm)
  );

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .PERM_W(PERM_W)
  ) u_match (
    .clk_i, .rst_ni,
    .valid_i(valid), .vpn_i(vpn), .asid_i(asid), .pfn_i(pfn), .perm_i(perm),
    .lkp_vpn_i, .lkp_asid_i,
    .upd_vpn_i(fill_vpn_i), .upd_asid_i(fill_asid_i),
    .lkp_hit_o, .lkp_pfn_o, .lkp_perm_o,
    .upd_hit_o(upd_hit), .upd_idx_o(upd_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i, .rst_ni,
    .fire_i(fill_en_i), .valid_i(valid), .wired_i(wired),
    .upd_hit_i(upd_hit), .upd_idx_i(upd_idx),
    .kind_o(kind), .idx_o(vic_idx)
  );

  assign wr_en = fill_en_i && kind != FILL_DROP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= fill_en_i && kind == FILL_DROP;
  end

  assign fill_err_o = err_q;

  AST_ERR_AFTER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_err_o |-> $past(fill_en_i)); // R8
  AST_ERR_ALL_PINNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_err_o |-> $past(&wired)); // R8
endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] lkp_vpn = '0;
  logic [7:0]  lkp_asid = '0;
  logic        lkp_hit;
  logic [19:0] lkp_pfn;
  logic [2:0]  lkp_perm;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_wired = 1'b0;
  logic        fill_err;
  logic        fl_all = 1'b0;
  logic        fl_as_en = 1'b0;
  logic [7:0]  fl_asid = '0;

  always #2 clk = ~clk;

  asid_tlb #(.ENTRIES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_vpn_i(lkp_vpn), .lkp_asid_i(lkp_asid),
    .lkp_hit_o(lkp_hit), .lkp_pfn_o(lkp_pfn), .lkp_perm_o(lkp_perm),
    .fill_en_i(fill_en), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_perm_i(fill_perm), .fill_wired_i(fill_wired),
    .fill_err_o(fill_err),
    .flush_all_i(fl_all), .flush_asid_en_i(fl_as_en), .flush_asid_i(fl_asid)
  );

  // reference model
  bit          m_v [N];
  bit          m_w [N];
  logic [19:0] m_vpn [N];
  logic [7:0]  m_asid [N];
  logic [19:0] m_pfn [N];
  logic [2:0]  m_perm [N];
  int          m_rr;
  bit          m_err;

  typedef struct packed {
    logic        hit;
    logic [19:0] pfn;
    logic [2:0]  perm;
    logic        err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {lkp_hit, lkp_pfn, lkp_perm}, {e.hit, e.pfn, e.perm});
        chk(t, {23'd0, fill_err}, {23'd0, e.err});
      end
    end
  end

  task automatic cyc(input bit f_en, input logic [19:0] f_vpn, input logic [7:0] f_asid,
                     input logic [19:0] f_pfn, input logic [2:0] f_perm, input bit f_w,
                     input bit fa, input bit fs, input logic [7:0] fs_asid,
                     input logic [19:0] l_vpn, input logic [7:0] l_asid, input string tag);
    exp_t e;
    int   wi;
    bit   drop, evict;
    @(posedge clk);
    #1;
    fill_en = f_en; fill_vpn = f_vpn; fill_asid = f_asid; fill_pfn = f_pfn;
    fill_perm = f_perm; fill_wired = f_w;
    fl_all = fa; fl_as_en = fs; fl_asid = fs_asid;
    lkp_vpn = l_vpn; lkp_asid = l_asid;
    e = '0;
    e.err = m_err;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == l_vpn && m_asid[i] == l_asid) begin
        e.hit = 1'b1; e.pfn = m_pfn[i]; e.perm = m_perm[i];
      end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    // model update for the coming edge
    wi = -1; drop = 0; evict = 0;
    if (f_en) begin
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_vpn[i] == f_vpn && m_asid[i] == f_asid) wi = i;
      if (wi < 0)
        for (int i = N - 1; i >= 0; i--) if (!m_v[i] && !m_w[i]) wi = i;
      if (wi < 0) begin
        for (int k = N - 1; k >= 0; k--) if (!m_w[(m_rr + k) % N]) wi = (m_rr + k) % N;
        if (wi >= 0) evict = 1;
      end
      if (wi < 0) drop = 1;
    end
    for (int i = 0; i < N; i++)
      if (i != wi && !m_w[i] && (fa || (fs && m_asid[i] == fs_asid))) m_v[i] = 0;
    if (wi >= 0) begin
      m_v[wi] = 1; m_w[wi] = m_w[wi] | f_w;
      m_vpn[wi] = f_vpn; m_asid[wi] = f_asid; m_pfn[wi] = f_pfn; m_perm[wi] = f_perm;
    end
    if (evict) m_rr = (wi + 1) % N;
    m_err = f_en && drop;
  endtask

  task automatic look(input logic [19:0] v, input logic [7:0] a, input string tag);
    cyc(0, '0, '0, '0, '0, 0, 0, 0, '0, v, a, tag);
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                      input logic [2:0] pm, input bit w, input string tag);
    cyc(1, v, a, p, pm, w, 0, 0, '0, '0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_w[i] = 0; m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
    end
    m_rr = 0; m_err = 0;
    #5;
    chk("R12 reset outputs", {lkp_hit, lkp_pfn, lkp_perm}, 24'd0);
    chk("R12 reset err", {23'd0, fill_err}, 24'd0);
    #2 rst_n = 1'b1;

    look(20'h0, 8'h0, "R12 post-reset miss");
    look(20'h100, 8'd1, "R2 miss on empty");
    fill(20'h100, 8'd1, 20'h00AAA, 3'd5, 0, "R3 fill");
    look(20'h100, 8'd1, "R3 hit after fill");
    look(20'h100, 8'd2, "R1 asid mismatch misses");
    look(20'h101, 8'd1, "R1 vpn mismatch misses");
    fill(20'h100, 8'd2, 20'h00BBB, 3'd2, 0, "R1 second asid fill");
    look(20'h100, 8'd2, "R1 asid 2 frame");
    look(20'h100, 8'd1, "R1 asid 1 frame");
    // R13: lookup coincides with fill of same page
    cyc(1, 20'h200, 8'd1, 20'h00DDD, 3'd7, 0, 0, 0, '0, 20'h200, 8'd1, "R13 same-cycle lookup old");
    look(20'h200, 8'd1, "R13 visible next cycle");
    fill(20'h100, 8'd1, 20'h00CCC, 3'd1, 0, "R4 refill same page");
    look(20'h100, 8'd1, "R4 overwritten in place");
    cyc(0, '0, '0, '0, '0, 0, 0, 1, 8'd2, 20'h100, 8'd2, "R10 flush asid 2 cycle");
    look(20'h100, 8'd2, "R10 asid 2 gone");
    look(20'h100, 8'd1, "R10 asid 1 kept");
    fill(20'h300, 8'd3, 20'h00EEE, 3'd4, 1, "R5 wired into freed slot");
    cyc(0, '0, '0, '0, '0, 0, 1, 0, '0, 20'h300, 8'd3, "R9 flush all cycle");
    look(20'h300, 8'd3, "R9 wired survives");
    look(20'h100, 8'd1, "R9 non-wired gone");
    look(20'h200, 8'd1, "R9 non-wired gone");
    // R11: fill with flush in same cycle
    cyc(1, 20'h400, 8'd1, 20'h00F0F, 3'd3, 0, 1, 0, '0, '0, '0, "R11 fill plus flush");
    look(20'h400, 8'd1, "R11 filled entry survives");
    look(20'h300, 8'd3, "R11 wired survives");
    cyc(1, 20'h500, 8'd6, 20'h00123, 3'd6, 0, 0, 1, 8'd1, '0, '0, "R11 fill plus asid flush");
    look(20'h500, 8'd6, "R11 survives asid flush");
    look(20'h400, 8'd1, "R11 asid 1 flushed");
    // fill beyond capacity: free slots then round-robin
    for (int i = 0; i < N + 3; i++)
      fill(20'h1000 + 20'(i), 8'd4, 20'h05000 + 20'(i), 3'(i), 0, "R5 R6 bulk fill");
    for (int i = 0; i < N + 3; i++)
      look(20'h1000 + 20'(i), 8'd4, "R6 round-robin contents");
    look(20'h300, 8'd3, "R7 wired kept under eviction");
    look(20'h500, 8'd6, "R6 evicted or kept");
    // pin everything
    for (int i = 0; i < N; i++) begin
      fill(20'h2000 + 20'(i), 8'd5, 20'h06000 + 20'(i), 3'd2, 1, "R7 wired fill");
      look(20'h300, 8'd3, "R7 wired entry never evicted");
    end
    look(20'h2000, 8'd5, "R8 error pulse check");
    fill(20'h2000, 8'd5, 20'h07777, 3'd1, 1, "R4 update of wired slot");
    look(20'h2000, 8'd5, "R4 wired update visible");
    look(20'h3000, 8'd5, "R8 dropped fill absent");
    cyc(0, '0, '0, '0, '0, 0, 1, 1, 8'd5, 20'h2001, 8'd5, "R9 flush with all wired");
    for (int i = 0; i < N; i++)
      look(20'h2000 + 20'(i), 8'd5, "R9 R10 all wired still hit");
    look(20'h300, 8'd3, "R7 final");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule